// File: doc/BRIEF.md
# Routed Two-Group Interrupt Controller

This block gathers two groups of sixteen level-sensitive interrupt sources and steers them onto five output interrupt lines. A source counts as active while its input level is high and its enable bit is set. Each active source is steered to one line. Some pins in each group can be steered to any line through 3-bit routing fields. All other pins always go to line 0. Each output line is the OR of the active sources steered to it, taken through one register stage.

Next to each line the block gives a claim result that names the source a handler should serve. The claim searches group 1 first, then group 2, and within a group takes the lowest pin. When nothing matches, the claim reads as not valid. Software sets the enable and routing registers through a small 16-bit register port with two address windows: window 0 holds the group 1 registers and window 1 holds the group 2 registers.

Register layout, as byte offsets. Window 0: group 1 levels at 0x00 (read only), routing word A at 0x04, routing word B at 0x06, group 1 enables at 0x0C, routing word C at 0x1C and routing word D at 0x1E. Window 1: group 2 levels at 0x00 (read only) and group 2 enables at 0x06. A routing word has five 3-bit slots, with slot k at bits 3k+2..3k.

Top module: `routed_irq_ctrl`

## Requirements
- R1: After reset, both enable registers read 0x0000, routing words A, B, C and D read 0x0040, 0x0000, 0x0002 and 0x0000, and every line and claim output is 0.
- R2: A source drives a line only while its level input is 1 and its enable bit is 1. An enable bit of 0 blocks the source.
- R3: The enable registers read back the last value written. A read of a level register returns the current source inputs, and a write to a level register has no effect.
- R4: A routing slot takes a written value only when that value is 0 to 4. A value of 5 to 7 leaves that slot as it was, and each slot in the written word is judged on its own.
- R5: Group 1 routing: word A slots 0 to 4 steer pins 0, 1, 2, 3 and 8. Word B slot 0 steers pin 9, slot 2 steers pin 11 and slot 3 steers pin 12. Word B slots 1 and 4, and bit 15 of every routing word, always read 0.
- R6: Group 2 routing uses words C and D, which sit in window 0. Word C slots 0 to 4 steer pins 0, 1, 3, 4 and 5. Word D slots 0 to 4 steer pins 6, 7, 8, 9 and 10.
- R7: Pins that have no routing slot always steer to line 0.
- R8: Line k goes high on the clock edge after at least one active source is steered to line k, and goes low on the edge after no such source remains.
- R9: The claim for line k gives the group (0 means group 1, 1 means group 2) and the 4-bit pin index of the winner. Any active group 1 source beats every group 2 source, and within a group the lowest pin wins. The claim is valid exactly when line k is high.
- R10: When no active source is steered to a line, its claim valid bit is 0, and its group and pin outputs are 0.
- R11: Reads of odd offsets or of offsets with no register return 0, and writes to them change nothing. This includes offsets 0x1C and 0x1E in window 1.
- R12: A read request returns its data with the read-valid flag on the next clock cycle. The read-valid flag is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_g1_i | input | 16 | Group 1 source levels |
| src_g2_i | input | 16 | Group 2 source levels |
| bus_req_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 for a write, 0 for a read |
| bus_win_i | input | 1 | Window select: 0 for group 1, 1 for group 2 |
| bus_addr_i | input | 5 | Byte offset inside the window |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data |
| bus_rvalid_o | output | 1 | Read data valid |
| irq_line_o | output | 5 | Output interrupt lines |
| claim_valid_o | output | 5 | Per-line claim valid flag |
| claim_grp_o | output | 5 | Per-line winning group |
| claim_pin_o | output | 20 | Per-line winning pin, 4 bits per line, line k at bits 4k+3..4k |

## Verification
The routing function is first tried with reset routing under a table of level and enable patterns. A lone enabled source, the same source blocked by its enable bit, sources from both groups on different lines, all sources high, and no sources separate the gating, steering and idle-claim behaviour. Directed writes then place legal and illegal values in a single routing word, which shows whether each slot is judged on its own. Competing sources on one line, in the same group and across groups, show whether the lowest pin wins and whether group 1 wins over group 2. Accesses to the window 1 copies of the group 2 routing offsets, and to holes in the address map, show that routing words are reached only through window 0.

// File: rtl/rtic_pkg.sv
package rtic_pkg;
    localparam int DW     = 16;
    localparam int AW     = 5;
    localparam int NPIN   = 16;
    localparam int NLINE  = 5;
    localparam int FW     = 3;
    localparam int SLOTS  = 5;
    localparam int NWORD  = 4;
    localparam int PINW   = $clog2(NPIN);

    typedef enum logic [3:0] {
        SEL_NONE, SEL_LVL1, SEL_EN1, SEL_RWA, SEL_RWB,
        SEL_RWC, SEL_RWD, SEL_LVL2, SEL_EN2
    } reg_sel_e;

    // slot-present map per routing word, word w at [w*SLOTS +: SLOTS]
    localparam logic [NWORD*SLOTS-1:0] SLOT_USED = {5'b11111, 5'b11111, 5'b01101, 5'b11111};
    // reset contents, word w at [w*DW +: DW]
    localparam logic [NWORD*DW-1:0] WORDS_RST = {16'h0000, 16'h0002, 16'h0000, 16'h0040};

    function automatic reg_sel_e decode_sel(input logic win, input logic [AW-1:0] a);
        reg_sel_e s;
        s = SEL_NONE;
        if (!a[0]) begin
            if (!win) begin
                unique case (a)
                    5'h00:   s = SEL_LVL1;
                    5'h04:   s = SEL_RWA;
                    5'h06:   s = SEL_RWB;
                    5'h0C:   s = SEL_EN1;
                    5'h1C:   s = SEL_RWC;
                    5'h1E:   s = SEL_RWD;
                    default: s = SEL_NONE;
                endcase
            end else begin
                unique case (a)
                    5'h00:   s = SEL_LVL2;
                    5'h06:   s = SEL_EN2;
                    default: s = SEL_NONE;
                endcase
            end
        end
        return s;
    endfunction

    // merge a written routing word: keep old slot when new value is out of range
    function automatic logic [DW-1:0] merge_word(input logic [DW-1:0] old_w,
                                                 input logic [DW-1:0] new_w,
                                                 input logic [SLOTS-1:0] used);
        logic [DW-1:0] res;
        res = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (used[s]) begin
                if (new_w[s*FW +: FW] < FW'(NLINE))
                    res[s*FW +: FW] = new_w[s*FW +: FW];
                else
                    res[s*FW +: FW] = old_w[s*FW +: FW];
            end
        end
        return res;
    endfunction

    // where a pin's routing slot lives; ok=0 means fixed to line 0
    function automatic logic [5:0] pin_slot(input int grp, input int pin);
        logic       ok;
        logic [1:0] w;
        logic [2:0] s;
        ok = 1'b1; w = 2'd0; s = 3'd0;
        if (grp == 0) begin
            unique case (pin)
                0, 1, 2, 3: begin w = 2'd0; s = 3'(pin); end
                8:          begin w = 2'd0; s = 3'd4; end
                9:          begin w = 2'd1; s = 3'd0; end
                11:         begin w = 2'd1; s = 3'd2; end
                12:         begin w = 2'd1; s = 3'd3; end
                default:    ok = 1'b0;
            endcase
        end else begin
            unique case (pin)
                0, 1:                begin w = 2'd2; s = 3'(pin); end
                3, 4, 5:             begin w = 2'd2; s = 3'(pin - 1); end
                6, 7, 8, 9, 10:      begin w = 2'd3; s = 3'(pin - 6); end
                default:             ok = 1'b0;
            endcase
        end
        return {ok, w, s};
    endfunction
endpackage

// File: rtl/rtic_regs.sv
module rtic_regs
    import rtic_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req,
    input  logic                  we,
    input  logic                  win,
    input  logic [AW-1:0]         addr,
    input  logic [DW-1:0]         wdata,
    input  logic [NPIN-1:0]       lvl1,
    input  logic [NPIN-1:0]       lvl2,
    output logic [NPIN-1:0]       en1,
    output logic [NPIN-1:0]       en2,
    output logic [NWORD*DW-1:0]   words,
    output logic [DW-1:0]         rdata,
    output logic                  rvalid
);
    reg_sel_e      sel;
    logic [DW-1:0] rd_mux;

    assign sel = decode_sel(win, addr);

    always_comb begin
        unique case (sel)
            SEL_LVL1: rd_mux = lvl1;
            SEL_EN1:  rd_mux = en1;
            SEL_RWA:  rd_mux = words[0*DW +: DW];
            SEL_RWB:  rd_mux = words[1*DW +: DW];
            SEL_RWC:  rd_mux = words[2*DW +: DW];
            SEL_RWD:  rd_mux = words[3*DW +: DW];
            SEL_LVL2: rd_mux = lvl2;
            SEL_EN2:  rd_mux = en2;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en1    <= '0;
            en2    <= '0;
            words  <= WORDS_RST;
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= req && !we;
            if (req && !we)
                rdata <= rd_mux;
            if (req && we) begin
                unique case (sel)
                    SEL_EN1: en1 <= wdata;
                    SEL_EN2: en2 <= wdata;
                    SEL_RWA: words[0*DW +: DW] <= merge_word(words[0*DW +: DW], wdata, SLOT_USED[0*SLOTS +: SLOTS]);
                    SEL_RWB: words[1*DW +: DW] <= merge_word(words[1*DW +: DW], wdata, SLOT_USED[1*SLOTS +: SLOTS]);
                    SEL_RWC: words[2*DW +: DW] <= merge_word(words[2*DW +: DW], wdata, SLOT_USED[2*SLOTS +: SLOTS]);
                    SEL_RWD: words[3*DW +: DW] <= merge_word(words[3*DW +: DW], wdata, SLOT_USED[3*SLOTS +: SLOTS]);
                    default: ;
                endcase
            end
        end
    end

    a_r12_read_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we) |=> rvalid);
    a_r12_no_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && !we) |=> !rvalid);
    a_r3_enable_written: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && sel == SEL_EN1) |=> (en1 == $past(wdata)));
    a_r4_bad_slot_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && sel == SEL_RWA && wdata[FW-1:0] >= FW'(NLINE)) |=> $stable(words[FW-1:0]));
    a_r11_dead_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && (sel == SEL_NONE || sel == SEL_LVL1 || sel == SEL_LVL2))
        |=> ($stable(en1) && $stable(en2) && $stable(words)));
endmodule

// File: rtl/rtic_route.sv
module rtic_route
    import rtic_pkg::*;
#(
    parameter int GROUP = 0
) (
    input  logic [NPIN-1:0]        lvl,
    input  logic [NPIN-1:0]        en,
    input  logic [NWORD*DW-1:0]    words,
    output logic [NLINE*NPIN-1:0]  hit
);
    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        localparam logic [5:0] LOC  = pin_slot(GROUP, p);
        localparam int         WIDX = int'(LOC[4:3]);
        localparam int         SIDX = int'(LOC[2:0]);
        logic [FW-1:0] dest;
        if (LOC[5]) begin : g_routed
            assign dest = words[WIDX*DW + SIDX*FW +: FW];
        end else begin : g_fixed
            assign dest = '0;
        end
        for (genvar l = 0; l < NLINE; l++) begin : g_ln
            assign hit[l*NPIN + p] = lvl[p] && en[p] && (dest == FW'(l));
        end
    end
endmodule

// File: rtl/rtic_claim.sv
module rtic_claim
    import rtic_pkg::*;
(
    input  logic [NLINE*NPIN-1:0]  hit_a,
    input  logic [NLINE*NPIN-1:0]  hit_b,
    output logic [NLINE-1:0]       valid,
    output logic [NLINE-1:0]       grp,
    output logic [NLINE*PINW-1:0]  pin
);
    always_comb begin
        valid = '0;
        grp   = '0;
        pin   = '0;
        for (int l = 0; l < NLINE; l++) begin
            // descending scan: last match kept is the lowest pin; group 1 overrides
            for (int p = NPIN - 1; p >= 0; p--) begin
                if (hit_b[l*NPIN + p]) begin
                    valid[l]            = 1'b1;
                    grp[l]              = 1'b1;
                    pin[l*PINW +: PINW] = PINW'(p);
                end
            end
            for (int p = NPIN - 1; p >= 0; p--) begin
                if (hit_a[l*NPIN + p]) begin
                    valid[l]            = 1'b1;
                    grp[l]              = 1'b0;
                    pin[l*PINW +: PINW] = PINW'(p);
                end
            end
        end
    end
endmodule

// File: rtl/routed_irq_ctrl.sv
module routed_irq_ctrl
    import rtic_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic [15:0]  src_g1_i,
    input  logic [15:0]  src_g2_i,
    input  logic         bus_req_i,
    input  logic         bus_we_i,
    input  logic         bus_win_i,
    input  logic [4:0]   bus_addr_i,
    input  logic [15:0]  bus_wdata_i,
    output logic [15:0]  bus_rdata_o,
    output logic         bus_rvalid_o,
    output logic [4:0]   irq_line_o,
    output logic [4:0]   claim_valid_o,
    output logic [4:0]   claim_grp_o,
    output logic [19:0]  claim_pin_o
);
    logic [NPIN-1:0]       en1, en2;
    logic [NWORD*DW-1:0]   words;
    logic [NLINE*NPIN-1:0] hit_a, hit_b;
    logic [NLINE-1:0]      line_nx, cv_nx, cg_nx;
    logic [NLINE*PINW-1:0] cp_nx;

    rtic_regs u_regs (
        .clk(clk), .rst_n(rst_n), .req(bus_req_i), .we(bus_we_i), .win(bus_win_i),
        .addr(bus_addr_i), .wdata(bus_wdata_i), .lvl1(src_g1_i), .lvl2(src_g2_i),
        .en1(en1), .en2(en2), .words(words), .rdata(bus_rdata_o), .rvalid(bus_rvalid_o)
    );

    rtic_route #(.GROUP(0)) u_route_g1 (.lvl(src_g1_i), .en(en1), .words(words), .hit(hit_a));
    rtic_route #(.GROUP(1)) u_route_g2 (.lvl(src_g2_i), .en(en2), .words(words), .hit(hit_b));

    rtic_claim u_claim (.hit_a(hit_a), .hit_b(hit_b), .valid(cv_nx), .grp(cg_nx), .pin(cp_nx));

    for (genvar l = 0; l < NLINE; l++) begin : g_or
        assign line_nx[l] = |hit_a[l*NPIN +: NPIN] || |hit_b[l*NPIN +: NPIN];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_line_o    <= '0;
            claim_valid_o <= '0;
            claim_grp_o   <= '0;
            claim_pin_o   <= '0;
        end else begin
            irq_line_o    <= line_nx;
            claim_valid_o <= cv_nx;
            claim_grp_o   <= cg_nx;
            claim_pin_o   <= cp_nx;
        end
    end

    a_r9_claim_tracks_line: assert property (@(posedge clk) disable iff (!rst_n)
        claim_valid_o == irq_line_o);
    a_r2_line_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_line_o) |-> $past((|(src_g1_i & en1)) || (|(src_g2_i & en2))));
    for (genvar l = 0; l < NLINE; l++) begin : g_chk
        a_r10_idle_claim_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !claim_valid_o[l] |-> (!claim_grp_o[l] && claim_pin_o[l*PINW +: PINW] == '0));
    end
endmodule

// File: tb/routed_irq_ctrl_test.sv
module routed_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_g1_i = '0, src_g2_i = '0;
    logic        bus_req_i = 1'b0, bus_we_i = 1'b0, bus_win_i = 1'b0;
    logic [4:0]  bus_addr_i = '0;
    logic [15:0] bus_wdata_i = '0;
    logic [15:0] bus_rdata_o;
    logic        bus_rvalid_o;
    logic [4:0]  irq_line_o, claim_valid_o, claim_grp_o;
    logic [19:0] claim_pin_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    routed_irq_ctrl uut (.*);

    typedef struct packed {
        logic [15:0] s1, s2, m1, m2;
        logic [4:0]  lines;
        logic [29:0] claims;   // line l at [6l+:6] = {valid, group, pin[3:0]}
    } vec_t;

    localparam vec_t VEC [7] = '{
        '{16'h0004, 16'h0000, 16'hFFFF, 16'hFFFF, 5'b00010, 30'h0000_0880},
        '{16'h0004, 16'h0000, 16'hFFFB, 16'hFFFF, 5'b00000, 30'h0000_0000},
        '{16'h8010, 16'h0001, 16'hFFFF, 16'hFFFF, 5'b00101, 30'h0003_0024},
        '{16'h0000, 16'h0C00, 16'hFFFF, 16'h0800, 5'b00001, 30'h0000_003B},
        '{16'h0001, 16'h0002, 16'h0000, 16'hFFFF, 5'b00001, 30'h0000_0031},
        '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 5'b00111, 30'h0003_08A0},
        '{16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF, 5'b00000, 30'h0000_0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [29:0] claims_now();
        logic [29:0] c;
        for (int l = 0; l < 5; l++)
            c[l*6 +: 6] = {claim_valid_o[l], claim_grp_o[l], claim_pin_o[l*4 +: 4]};
        return c;
    endfunction

    task automatic bus_write(input logic win, input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_req_i = 1'b1; bus_we_i = 1'b1; bus_win_i = win; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_req_i = 1'b0; bus_we_i = 1'b0;
    endtask

    task automatic bus_read_chk(input string req, input logic win, input logic [4:0] a,
                                input logic [15:0] exp);
        @(negedge clk);
        bus_req_i = 1'b1; bus_we_i = 1'b0; bus_win_i = win; bus_addr_i = a;
        @(negedge clk);
        bus_req_i = 1'b0;
        check("R12 read valid", 32'(bus_rvalid_o), 32'd1);
        check(req, 32'(bus_rdata_o), 32'(exp));
        @(negedge clk);
        check("R12 valid drops", 32'(bus_rvalid_o), 32'd0);
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic drive_chk(input string req, input logic [15:0] s1, input logic [15:0] s2,
                             input logic [4:0] lines, input logic [29:0] cl);
        src_g1_i = s1; src_g2_i = s2;
        settle();
        check({req, " lines"}, 32'(irq_line_o), 32'(lines));
        check({req, " claim"}, 32'(claims_now()), 32'(cl));
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 lines", 32'(irq_line_o), 32'd0);
        check("R1 claims", 32'(claims_now()), 32'd0);
        bus_read_chk("R1 enable g1", 1'b0, 5'h0C, 16'h0000);
        bus_read_chk("R1 enable g2", 1'b1, 5'h06, 16'h0000);
        bus_read_chk("R1 word A", 1'b0, 5'h04, 16'h0040);
        bus_read_chk("R1 word B", 1'b0, 5'h06, 16'h0000);
        bus_read_chk("R1 word C", 1'b0, 5'h1C, 16'h0002);
        bus_read_chk("R1 word D", 1'b0, 5'h1E, 16'h0000);

        // R2 R8 R9 R10: table of patterns under reset routing
        for (int i = 0; i < 7; i++) begin
            bus_write(1'b0, 5'h0C, VEC[i].m1);
            bus_write(1'b1, 5'h06, VEC[i].m2);
            drive_chk($sformatf("R2/R8/R10 vec%0d", i), VEC[i].s1, VEC[i].s2, VEC[i].lines, VEC[i].claims);
        end

        // R4: per-slot legality, bit 15 dropped
        bus_write(1'b0, 5'h04, 16'hD1DC);
        bus_read_chk("R4 word A merge", 1'b0, 5'h04, 16'h005C);
        drive_chk("R4 pin0 to line4", 16'h0001, 16'h0000, 5'b10000, 30'h2000_0000);

        // R5: word B slot map
        bus_write(1'b0, 5'h06, 16'hA31A);
        bus_read_chk("R5 word B", 1'b0, 5'h06, 16'h0302);
        drive_chk("R5 pin11 to line4", 16'h0800, 16'h0000, 5'b10000, 30'h2B00_0000);
        drive_chk("R9 lowest pin", 16'h0801, 16'h0000, 5'b10000, 30'h2000_0000);

        // R7: unrouted pin stays on line 0
        drive_chk("R7 pin10 fixed", 16'h0400, 16'h0000, 5'b00001, 30'h0000_002A);

        // R6: group 2 words
        bus_write(1'b0, 5'h1C, 16'h0853);
        bus_read_chk("R6 word C", 1'b0, 5'h1C, 16'h0853);
        drive_chk("R6 g2 pin3", 16'h0000, 16'h0008, 5'b00010, 30'h0000_0CC0);
        drive_chk("R6 g2 pin0", 16'h0000, 16'h0001, 5'b01000, 30'h00C0_0000);
        bus_write(1'b0, 5'h1E, 16'h0004);
        bus_read_chk("R6 word D", 1'b0, 5'h1E, 16'h0004);
        drive_chk("R6 g2 pin6", 16'h0000, 16'h0040, 5'b10000, 30'h3600_0000);
        drive_chk("R9 group order", 16'h0800, 16'h0040, 5'b10000, 30'h2B00_0000);

        // R11: window 1 routing offsets and holes
        bus_write(1'b1, 5'h1C, 16'h0000);
        bus_read_chk("R11 word C kept", 1'b0, 5'h1C, 16'h0853);
        bus_read_chk("R11 win1 0x1C", 1'b1, 5'h1C, 16'h0000);
        bus_write(1'b0, 5'h0A, 16'hFFFF);
        bus_read_chk("R11 hole", 1'b0, 5'h0A, 16'h0000);
        bus_read_chk("R11 odd", 1'b0, 5'h0D, 16'h0000);

        // R3: level registers and enables
        src_g1_i = 16'h00A5; src_g2_i = 16'h5A00;
        bus_write(1'b0, 5'h00, 16'hFFFF);
        bus_read_chk("R3 level g1", 1'b0, 5'h00, 16'h00A5);
        bus_read_chk("R3 level g2", 1'b1, 5'h00, 16'h5A00);
        bus_write(1'b0, 5'h0C, 16'h1234);
        bus_read_chk("R3 enable g1", 1'b0, 5'h0C, 16'h1234);
        bus_read_chk("R3 enable g2", 1'b1, 5'h06, 16'hFFFF);

        finish_run();
    end
endmodule